// File: doc/BRIEF.md
# Periodic Down-Counting Tick Timer

This block is a periodic tick generator with a small word-addressed register bus. A down-counter of `CNT_W` bits (24 by default) decrements on every selected tick. The tick is either every core clock cycle or a single-cycle pulse on a reference-tick input. When the counter passes from one to zero, the block sets a sticky wrap flag and, if interrupts are enabled, pulses an interrupt request for one core cycle. The tick after the counter sits at zero reloads it from the reload register, so a reload value of N-1 gives a period of N ticks.

Software programs the reload value, writes the current-value register to zero the counter, and then sets the enable bit. It polls the wrap flag by reading the control word, and that read also clears the flag. A read-only calibration word reports build-time constants: the reload value for a 10 ms period, whether that value is inexact, and whether a reference tick exists at all. If no reference tick exists, the source-select bit reads back as core clock and the core clock is used. The reference tick is expected to arrive already synchronous to the core clock.

Top module: `tick_timer`

## Requirements
- R1: After reset the control, reload and current-value words all read 0 and the interrupt request is low.
- R2: Register selection uses address bits [3:2]: 0 selects control, 1 selects reload, 2 selects current value, 3 selects calibration. Read data appears on the output one cycle after the read strobe.
- R3: Reload and current value hold `CNT_W` bits, and their upper bits read 0. In the control word only bit 0 (enable), bit 1 (interrupt enable) and bit 2 (source select) are writable. Bit 16 is the wrap flag and ignores writes. All other bits read 0.
- R4: While enabled, each tick decrements a non-zero counter by one. A tick at zero loads the reload value, so consecutive wraps are reload+1 ticks apart.
- R5: The wrap flag is set when a tick moves the counter from 1 to 0. A control-word read returns the flag and then clears it. A wrap in the same cycle as the read leaves the flag set.
- R6: Any write to the current-value register zeroes the counter and clears the wrap flag, and it overrides a tick in the same cycle.
- R7: With interrupt enable set, each wrap pulses the interrupt request high for exactly one core cycle. With it clear, the request stays low while the flag still sets.
- R8: Source select = 1 ticks on every core cycle. Source select = 0 ticks only on cycles where the reference-tick input is high.
- R9: With reload 0, the counter stays at 0 and no further wrap or interrupt occurs.
- R10: The calibration word holds the 10 ms reload value in bits [CNT_W-1:0], the inexact bit in bit 30 and the no-reference bit in bit 31. Writes to it have no effect.
- R11: When `NO_EXT_REF` is set, source select reads back 1 and the core clock is used whatever value was written.
- R12: With enable clear, the counter holds its value regardless of ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_tick_i | input | 1 | Reference tick pulse, synchronous to clk |
| addr_i | input | 4 | Byte address; bits [3:2] select the register |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Registered read data |
| irq_o | output | 1 | One-cycle interrupt request pulse |

## Verification
The embedded assertions check several rules on every cycle: the step-by-one decrement, the hold while no tick arrives, the zeroing by a current-value write, the set priority of the wrap flag over a read, the single-cycle width of the interrupt pulse and its coincidence with a zero count. Only the bench scenarios can show the complete period in ticks, the gating by the reference-tick input, the field layout and masking of each register, the read-clear sequence seen over the bus, and the core-clock fallback of an instance built without a reference tick.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 4;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_RELOAD = 2'd1,
    SEL_COUNT  = 2'd2,
    SEL_CAL    = 2'd3
  } reg_sel_e;

  localparam int unsigned BIT_EN       = 0;
  localparam int unsigned BIT_IRQ_EN   = 1;
  localparam int unsigned BIT_SRC_CORE = 2;
  localparam int unsigned BIT_WRAP     = 16;
  localparam int unsigned BIT_INEXACT  = 30;
  localparam int unsigned BIT_NO_REF   = 31;
endpackage

// File: rtl/tt_rst_sync.sv
module tt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/tt_tick_sel.sv
module tt_tick_sel (
  input  logic enable_i,
  input  logic src_core_i,
  input  logic ref_tick_i,
  output logic tick_o
);
  always_comb begin
    tick_o = 1'b0;
    if (enable_i) tick_o = src_core_i ? 1'b1 : ref_tick_i;
  end
endmodule

// File: rtl/tt_counter.sv
module tt_counter #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;

  always_comb begin
    cnt_d  = cnt_q;
    wrap_o = 1'b0;
    cnt_ce = clr_i | tick_i;
    if (clr_i) begin
      cnt_d = '0;
    end else if (tick_i) begin
      if (cnt_q == '0) begin
        cnt_d = reload_i;
      end else begin
        cnt_d  = cnt_q - ONE;
        wrap_o = (cnt_q == ONE);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R4: a tick on a non-zero count steps down by exactly one
  a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !clr_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));

  // R6: a current-value write leaves the counter at zero
  a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));

  // R12: no tick and no clear means the count holds
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !clr_i) |=> $stable(cnt_q));

  // R9: a zero reload keeps a zero counter at zero
  a_r9_zero_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && cnt_q == '0 && reload_i == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/tt_regs.sv
module tt_regs
  import tt_pkg::*;
#(
  parameter int unsigned CNT_W       = 24,
  parameter logic [CNT_W-1:0] CAL_TENMS = '0,
  parameter bit          CAL_INEXACT = 1'b0,
  parameter bit          NO_EXT_REF  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              wrap_i,
  output logic              enable_o,
  output logic              irq_en_o,
  output logic              src_core_o,
  output logic              clr_cnt_o,
  output logic [CNT_W-1:0]  reload_o
);
  reg_sel_e sel;
  logic     wr_ctrl, wr_reload, rd_ctrl;

  logic             en_q, irq_en_q, src_q, flag_q;
  logic             en_d, irq_en_d, src_d, flag_d;
  logic             ctrl_ce, flag_ce, reload_ce;
  logic [CNT_W-1:0] reload_q, reload_d;
  logic [DATA_W-1:0] rd_q, rd_d;
  logic [DATA_W-1:0] ctrl_word, cal_word;

  assign sel       = reg_sel_e'(addr_i[3:2]);
  assign wr_ctrl   = wr_en_i && (sel == SEL_CTRL);
  assign wr_reload = wr_en_i && (sel == SEL_RELOAD);
  assign clr_cnt_o = wr_en_i && (sel == SEL_COUNT);
  assign rd_ctrl   = rd_en_i && (sel == SEL_CTRL);

  assign src_core_o = src_q | NO_EXT_REF;

  always_comb begin
    ctrl_word               = '0;
    ctrl_word[BIT_EN]       = en_q;
    ctrl_word[BIT_IRQ_EN]   = irq_en_q;
    ctrl_word[BIT_SRC_CORE] = src_core_o;
    ctrl_word[BIT_WRAP]     = flag_q;
  end

  always_comb begin
    cal_word              = '0;
    cal_word[CNT_W-1:0]   = CAL_TENMS;
    cal_word[BIT_INEXACT] = CAL_INEXACT;
    cal_word[BIT_NO_REF]  = NO_EXT_REF;
  end

  always_comb begin
    ctrl_ce  = wr_ctrl;
    en_d     = wr_data_i[BIT_EN];
    irq_en_d = wr_data_i[BIT_IRQ_EN];
    src_d    = wr_data_i[BIT_SRC_CORE];

    reload_ce = wr_reload;
    reload_d  = wr_data_i[CNT_W-1:0];

    flag_ce = wrap_i | rd_ctrl | clr_cnt_o;
    flag_d  = wrap_i;

    rd_d = '0;
    unique case (sel)
      SEL_CTRL:   rd_d = ctrl_word;
      SEL_RELOAD: rd_d[CNT_W-1:0] = reload_q;
      SEL_COUNT:  rd_d[CNT_W-1:0] = cnt_i;
      SEL_CAL:    rd_d = cal_word;
      default:    rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      irq_en_q <= 1'b0;
      src_q    <= 1'b0;
    end else if (ctrl_ce) begin
      en_q     <= en_d;
      irq_en_q <= irq_en_d;
      src_q    <= src_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_ce) flag_q <= flag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         reload_q <= '0;
    else if (reload_ce) reload_q <= reload_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_q <= '0;
    else if (rd_en_i) rd_q <= rd_d;
  end

  assign rd_data_o = rd_q;
  assign enable_o  = en_q;
  assign irq_en_o  = irq_en_q;
  assign reload_o  = reload_q;

  // R5: a wrap always leaves the flag set, even against a concurrent read
  a_r5_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_i |=> flag_q);

  // R5: a read without a wrap leaves the flag clear
  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ctrl && !wrap_i) |=> !flag_q);

  // R6: a current-value write clears the flag
  a_r6_write_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cnt_o |=> !flag_q);

  // R11: without a reference tick, source select always reports core clock
  a_r11_src_forced: assert property (@(posedge clk) disable iff (!rst_n)
    NO_EXT_REF |-> src_core_o);
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tt_pkg::*;
#(
  parameter int unsigned CNT_W       = 24,
  parameter logic [CNT_W-1:0] CAL_TENMS = '0,
  parameter bit          CAL_INEXACT = 1'b0,
  parameter bit          NO_EXT_REF  = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ref_tick_i,
  input  logic [3:0]  addr_i,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  input  logic        rd_en_i,
  output logic [31:0] rd_data_o,
  output logic        irq_o
);
  logic             rst_sync_n;
  logic             enable, irq_en, src_core, clr_cnt, tick, wrap;
  logic [CNT_W-1:0] reload, cnt;
  logic             irq_q, irq_d;

  tt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tt_regs #(
    .CNT_W       (CNT_W),
    .CAL_TENMS   (CAL_TENMS),
    .CAL_INEXACT (CAL_INEXACT),
    .NO_EXT_REF  (NO_EXT_REF)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .addr_i     (addr_i),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .rd_en_i    (rd_en_i),
    .rd_data_o  (rd_data_o),
    .cnt_i      (cnt),
    .wrap_i     (wrap),
    .enable_o   (enable),
    .irq_en_o   (irq_en),
    .src_core_o (src_core),
    .clr_cnt_o  (clr_cnt),
    .reload_o   (reload)
  );

  tt_tick_sel u_tick (
    .enable_i   (enable),
    .src_core_i (src_core),
    .ref_tick_i (ref_tick_i),
    .tick_o     (tick)
  );

  tt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tick_i   (tick),
    .clr_i    (clr_cnt),
    .reload_i (reload),
    .cnt_o    (cnt),
    .wrap_o   (wrap)
  );

  always_comb irq_d = wrap & irq_en;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) irq_q <= 1'b0;
    else             irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  // R7: the interrupt request never lasts two cycles
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_o |=> !irq_o);

  // R7: a request only accompanies a counter that just reached zero
  a_r7_at_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_o |-> (cnt == '0));
endmodule

// File: tb/tick_timer_tb.sv
`timescale 1ns/1ps
module tick_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data, rd_data_nr;
  logic        irq, irq_nr;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  logic [31:0] rd_main, rd_nr;

  localparam logic [23:0] CAL_VAL = 24'h0186A0;

  always #2.5 clk = ~clk;

  tick_timer #(.CAL_TENMS(CAL_VAL), .CAL_INEXACT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_tick_i(ref_tick), .addr_i(addr),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_en_i(rd_en),
    .rd_data_o(rd_data), .irq_o(irq));

  tick_timer #(.NO_EXT_REF(1'b1)) u_dut_nr (
    .clk(clk), .rst_n(rst_n), .ref_tick_i(ref_tick), .addr_i(addr),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_en_i(rd_en),
    .rd_data_o(rd_data_nr), .irq_o(irq_nr));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    rd_main = rd_data;
    rd_nr   = rd_data_nr;
  endtask

  task automatic ref_pulse();
    ref_tick = 1'b1;
    @(negedge clk);
    ref_tick = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 irq", {31'b0, irq}, 32'h0);
    bus_read(4'h0); check("R1 ctrl", rd_main, 32'h0);
    check("R11 nr src", rd_nr, 32'h4);
    bus_read(4'h4); check("R1 reload", rd_main, 32'h0);
    bus_read(4'h8); check("R1 count", rd_main, 32'h0);
  endtask

  task automatic t_cal();
    bus_read(4'hC); check("R10 cal", rd_main, {2'b01, 6'b0, CAL_VAL});
    check("R10 nr cal", rd_nr, 32'h8000_0000);
    bus_write(4'hC, 32'hFFFF_FFFF);
    bus_read(4'hC); check("R10 cal write ignored", rd_main, {2'b01, 6'b0, CAL_VAL});
  endtask

  task automatic t_mask();
    bus_write(4'h4, 32'hFFFF_FFFF);
    bus_read(4'h4); check("R3 reload mask", rd_main, 32'h00FF_FFFF);
    bus_read(4'h5); check("R2 low addr bits ignored", rd_main, 32'h00FF_FFFF);
    bus_write(4'h0, 32'hFFFE_FFF8);
    bus_read(4'h0); check("R3 ctrl writable bits", rd_main, 32'h0);
  endtask

  task automatic t_period();
    int k;
    bit seen;
    bus_write(4'h4, 32'd4);
    bus_write(4'h8, 32'd0);
    bus_write(4'h0, 32'h7);
    seen = 1'b0;
    for (int i = 0; i < 50 && !seen; i++) begin
      @(negedge clk);
      if (irq) seen = 1'b1;
    end
    check("R7 first irq seen", {31'b0, seen}, 32'h1);
    k = 0;
    for (int i = 1; i <= 50; i++) begin
      @(negedge clk);
      if (irq) begin k = i; break; end
    end
    check("R4 period reload+1", k, 32'd5);
    bus_write(4'h0, 32'h0);
    check("R7 pulse one cycle", {31'b0, irq}, 32'h0);
    bus_read(4'h8); check("R4 load at zero", rd_main, 32'd4);
    bus_read(4'h0); check("R5 flag read", rd_main, 32'h0001_0000);
    bus_read(4'h0); check("R5 flag cleared", rd_main, 32'h0);
  endtask

  task automatic t_no_irq();
    bit seen;
    bus_write(4'h4, 32'd2);
    bus_write(4'h8, 32'd0);
    bus_read(4'h0);
    bus_write(4'h0, 32'h5);
    seen = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (irq) seen = 1'b1;
    end
    check("R7 no irq when disabled", {31'b0, seen}, 32'h0);
    bus_write(4'h0, 32'h0);
    bus_read(4'h0); check("R7 flag still sets", rd_main, 32'h0001_0000);
  endtask

  task automatic t_ref();
    bus_write(4'h4, 32'd3);
    bus_write(4'h8, 32'd0);
    bus_write(4'h0, 32'h1);
    bus_read(4'h0);
    check("R8 ctrl ext", rd_main, 32'h1);
    check("R11 nr src reads core", rd_nr, 32'h5);
    idle(5);
    bus_read(4'h8); check("R8 no ref no count", rd_main, 32'd0);
    ref_pulse();
    bus_read(4'h8); check("R8 ref load", rd_main, 32'd3);
    ref_pulse();
    bus_read(4'h8); check("R8 ref step", rd_main, 32'd2);
    ref_pulse();
    ref_pulse();
    bus_read(4'h0); check("R5 ext wrap flag", rd_main, 32'h0001_0001);
    check("R11 nr counts on core", rd_nr & 32'h0001_0000, 32'h0001_0000);
    bus_read(4'h0); check("R5 ext flag cleared", rd_main, 32'h1);
    ref_pulse();
    bus_write(4'h0, 32'h0);
    ref_pulse(); ref_pulse(); ref_pulse();
    bus_read(4'h8); check("R12 hold when disabled", rd_main, 32'd3);
  endtask

  task automatic t_clear();
    bus_write(4'h4, 32'd1);
    bus_write(4'h8, 32'd0);
    bus_write(4'h0, 32'h1);
    ref_pulse(); ref_pulse(); ref_pulse();
    bus_read(4'h8); check("R6 precondition count", rd_main, 32'd1);
    bus_write(4'h8, 32'h00AB_CDEF);
    bus_read(4'h8); check("R6 count zeroed", rd_main, 32'd0);
    bus_read(4'h0); check("R6 flag cleared", rd_main, 32'h1);
    bus_write(4'h0, 32'h0);
  endtask

  task automatic t_zero_reload();
    bit seen;
    bus_write(4'h4, 32'd0);
    bus_write(4'h8, 32'd0);
    bus_read(4'h0);
    bus_write(4'h0, 32'h7);
    seen = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (irq) seen = 1'b1;
    end
    check("R9 no irq", {31'b0, seen}, 32'h0);
    bus_read(4'h8); check("R9 count stays 0", rd_main, 32'd0);
    bus_read(4'h0); check("R9 no flag", rd_main, 32'h7);
    bus_write(4'h0, 32'h0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    idle(4);
    @(negedge clk) rst_n = 1'b1;
    idle(4);
    t_reset();
    t_cal();
    t_mask();
    t_period();
    t_no_irq();
    t_ref();
    t_clear();
    t_zero_reload();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule